// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block decides which of a small set of memory chip selects owns a physical address. Each chip select has one bounds word, written through a simple write port. The word holds a first-granule field and a last-granule field, and one granule is 16 MB. A lookup takes an address and, one clock later, returns three things: whether any chip select owns the address, the index of the owner, and the owner's byte range. The range is the owner's lowest byte address and its highest byte address, which software can use to express the range in pages. A separate output shows, for every chip select, whether its bounds describe a populated region.

A chip select whose first and last granule are equal is unpopulated and never owns an address. The last granule is inclusive. When several chip selects claim the same address, the lowest index wins. The decode outcome is held in a small result state register with three states:
- `RES_IDLE`: no lookup was presented.
- `RES_HIT`: the last lookup matched a chip select.
- `RES_MISS`: the last lookup fell outside every populated chip select.

On every clock the register takes a new state, and the state it came from does not matter. It moves to `RES_IDLE` when `lk_valid` is low. It moves to `RES_HIT` when a lookup matches. It moves to `RES_MISS` when a lookup matches nothing.

Top module: `csb_decoder`

## Requirements
- R1: After reset, every chip select reads as unpopulated (`cs_populated` is all zeros), the result state is `RES_IDLE`, and a lookup at any address misses.
- R2: Writing `cfg_wdata` with `cfg_we` high stores it as the bounds word of chip select `cfg_sel`. Bits 31:16 hold the first granule and bits 15:0 hold the last granule. From the next clock on, `cs_populated[cfg_sel]` is 1 exactly when the two fields differ.
- R3: The granule of an address is `lk_addr[39:24]`. A lookup presented with `lk_valid` at a clock edge produces `rsp_valid`=1 after that edge. `rsp_hit` is 1 when the granule lies between the first and last granule of some populated chip select. Full 40-bit addresses are decoded.
- R4: The last granule is inclusive. The byte at last×16 MB + 16 MB − 1 hits, and the byte at (last+1)×16 MB does not hit through that chip select.
- R5: A chip select whose first granule equals its last granule never matches, even at that granule.
- R6: When several chip selects match, `rsp_cs` is the lowest matching index.
- R7: On a miss, `rsp_valid`=1, `rsp_hit`=0, and `rsp_cs`, `rsp_base` and `rsp_last` are all 0.
- R8: On a hit, `rsp_base` is first×2^24 and `rsp_last` is last×2^24 + 0xFFFFFF, both taken from the owning chip select.
- R9: When `lk_valid` is low at a clock edge, `rsp_valid` is 0 after that edge.
- R10: A chip select whose first granule is greater than its last granule is populated but matches no address.
- R11: A lookup uses the bounds as they stood before the clock edge that samples it. A write at that same edge takes effect only for later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bounds write enable |
| cfg_sel | input | 2 | Chip select whose bounds word is written |
| cfg_wdata | input | 32 | Bounds word: first granule in 31:16, last granule in 15:0 |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 40 | Physical address to decode |
| cs_populated | output | 4 | Per chip select: first and last granule differ |
| rsp_valid | output | 1 | A lookup result is presented |
| rsp_hit | output | 1 | The looked-up address is owned by a chip select |
| rsp_cs | output | 2 | Owning chip select index, 0 on a miss |
| rsp_base | output | 40 | Lowest byte address of the owner, 0 on a miss |
| rsp_last | output | 40 | Highest byte address of the owner, 0 on a miss |

## Verification
A wrong result state shows at the ports one clock after the lookup. A state stuck in `RES_IDLE` drops `rsp_valid`. A state stuck in `RES_HIT` reports a hit where the address lies outside every range. A corrupted bounds word shows one clock after the write, either as a wrong `cs_populated` bit or as a wrong `rsp_base`/`rsp_last` on the next lookup in that region. The bench looks up addresses at both edges of each granule range, in overlapping, unpopulated and reversed ranges, and at addresses above 4 GB, so a wrong comparison or a wrong priority order shows up as a mismatched index or range.

// File: rtl/csb_pkg.sv
package csb_pkg;
    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } res_state_e;
endpackage

// File: rtl/csb_bounds_regs.sv
module csb_bounds_regs #(
    parameter int NUM_CS = 4,
    parameter int REG_W  = 32,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               sel,
    input  logic [REG_W-1:0]               wdata,
    output logic [NUM_CS-1:0][REG_W-1:0]   bounds
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                bounds[g] <= '0;
            else if (we && sel == IDX_W'(g))
                bounds[g] <= wdata;
        end
    end
endmodule

// File: rtl/csb_range_match.sv
module csb_range_match #(
    parameter int FIELD_W = 16,
    localparam int REG_W  = 2 * FIELD_W
) (
    input  logic [REG_W-1:0]   bounds,
    input  logic [FIELD_W-1:0] gran,
    output logic               populated,
    output logic               match
);
    logic [FIELD_W-1:0] first_g;
    logic [FIELD_W-1:0] last_g;

    always_comb begin
        first_g   = bounds[REG_W-1:FIELD_W];
        last_g    = bounds[FIELD_W-1:0];
        populated = (first_g != last_g);
        // inclusive upper limit; a reversed pair can never satisfy both sides
        match     = populated && (gran >= first_g) && (gran <= last_g);
    end
endmodule

// File: rtl/csb_prio_pick.sv
module csb_prio_pick #(
    parameter int NUM_CS = 4,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS-1:0] req,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan from the top so the lowest matching index is written last
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (req[i])
                idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/csb_decoder.sv
module csb_decoder
    import csb_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int ADDR_W     = 40,
    parameter int GRAN_SHIFT = 24,
    parameter int FIELD_W    = 16,
    localparam int REG_W     = 2 * FIELD_W,
    localparam int IDX_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [NUM_CS-1:0] cs_populated,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_cs,
    output logic [ADDR_W-1:0] rsp_base,
    output logic [ADDR_W-1:0] rsp_last
);
    localparam logic [ADDR_W-1:0] GRAN_MASK = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);

    logic [NUM_CS-1:0][REG_W-1:0] bounds;
    logic [NUM_CS-1:0]            match_vec;
    logic [FIELD_W-1:0]           gran;
    logic                         any_match;
    logic [IDX_W-1:0]             pick_idx;

    res_state_e        state_q, state_d;
    logic [IDX_W-1:0]  cs_q;
    logic [ADDR_W-1:0] base_q, last_q;
    logic [REG_W-1:0]  pick_bounds;

    csb_bounds_regs #(.NUM_CS(NUM_CS), .REG_W(REG_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .bounds (bounds)
    );

    assign gran = lk_addr[GRAN_SHIFT +: FIELD_W];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        csb_range_match #(.FIELD_W(FIELD_W)) u_cmp (
            .bounds    (bounds[g]),
            .gran      (gran),
            .populated (cs_populated[g]),
            .match     (match_vec[g])
        );
    end

    csb_prio_pick #(.NUM_CS(NUM_CS)) u_pick (
        .req (match_vec),
        .any (any_match),
        .idx (pick_idx)
    );

    // next-state selection
    always_comb begin
        if (!lk_valid)
            state_d = RES_IDLE;
        else if (any_match)
            state_d = RES_HIT;
        else
            state_d = RES_MISS;
        pick_bounds = bounds[pick_idx];
    end

    // state register and captured owner
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            cs_q    <= '0;
            base_q  <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == RES_HIT) begin
                cs_q   <= pick_idx;
                base_q <= ADDR_W'(pick_bounds[REG_W-1:FIELD_W]) << GRAN_SHIFT;
                last_q <= (ADDR_W'(pick_bounds[FIELD_W-1:0]) << GRAN_SHIFT) | GRAN_MASK;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_cs    = '0;
        rsp_base  = '0;
        rsp_last  = '0;
        unique case (state_q)
            RES_IDLE: ;
            RES_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_cs    = cs_q;
                rsp_base  = base_q;
                rsp_last  = last_q;
            end
            RES_MISS: rsp_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/csb_decoder_chk.sv
module csb_decoder_chk #(
    parameter int NUM_CS  = 4,
    parameter int ADDR_W  = 40,
    parameter int FIELD_W = 16,
    localparam int REG_W  = 2 * FIELD_W,
    localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W-1:0]  cfg_sel,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_addr,
    input logic [NUM_CS-1:0] cs_populated,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [IDX_W-1:0]  rsp_cs,
    input logic [ADDR_W-1:0] rsp_base,
    input logic [ADDR_W-1:0] rsp_last
);
    logic [NUM_CS-1:0] pop_d;
    logic [ADDR_W-1:0] addr_d;

    always_ff @(posedge clk) begin
        pop_d  <= cs_populated;
        addr_d <= lk_addr;
    end

    // R3
    lookup_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R9
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R7
    miss_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_cs == '0 && rsp_base == '0 && rsp_last == '0));

    // R8
    range_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_base < rsp_last && rsp_valid));

    // R3
    addr_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(rst_n)) |-> (addr_d >= rsp_base && addr_d <= rsp_last));

    // R5
    owner_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && $past(rst_n)) |-> pop_d[rsp_cs]);

    // R2
    populated_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cs_populated[$past(cfg_sel)] ==
                    ($past(cfg_wdata[REG_W-1:FIELD_W]) != $past(cfg_wdata[FIELD_W-1:0]))));
endmodule

bind csb_decoder csb_decoder_chk #(
    .NUM_CS  (NUM_CS),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .lk_valid     (lk_valid),
    .lk_addr      (lk_addr),
    .cs_populated (cs_populated),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_cs       (rsp_cs),
    .rsp_base     (rsp_base),
    .rsp_last     (rsp_last)
);

// File: tb/sim_csb_decoder.sv
module sim_csb_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_addr = '0;
    logic [3:0]  cs_populated;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_cs;
    logic [39:0] rsp_base, rsp_last;

    int n_tests = 0;
    int n_fail  = 0;
    bit mon_on  = 1'b0;

    typedef struct {
        logic        hit;
        logic [1:0]  cs;
        logic [39:0] base;
        logic [39:0] last;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model [4];

    always #2 clk = ~clk;

    csb_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .cs_populated(cs_populated), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_cs(rsp_cs), .rsp_base(rsp_base), .rsp_last(rsp_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(sel);
        cfg_wdata = d;
        model[sel] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic exp_t predict(input logic [39:0] a, input string tag);
        exp_t e;
        logic [15:0] g, s, l;
        e.hit = 1'b0; e.cs = '0; e.base = '0; e.last = '0; e.tag = tag;
        g = a[39:24];
        for (int i = 3; i >= 0; i--) begin
            s = model[i][31:16];
            l = model[i][15:0];
            if (s != l && g >= s && g <= l) begin
                e.hit  = 1'b1;
                e.cs   = 2'(i);
                e.base = {s, 24'h0};
                e.last = {l, 24'hFFFFFF};
            end
        end
        return e;
    endfunction

    task automatic look(input logic [39:0] a, input string tag);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        sb.push_back(predict(a, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // monitor: pop one expected item for every presented result
    always @(negedge clk) begin
        if (mon_on && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "result without lookup", 128'(rsp_valid), 128'(0));
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_hit == e.hit && rsp_cs == e.cs &&
                      rsp_base == e.base && rsp_last == e.last, e.tag,
                      "hit/cs/base/last",
                      {rsp_hit, rsp_cs, rsp_base, rsp_last},
                      {e.hit, e.cs, e.base, e.last});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 128'(0), 128'(1));
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(cs_populated == 4'b0000, "R1", "populated in reset", 128'(cs_populated), 128'(0));
        check(rsp_valid == 1'b0, "R1", "valid in reset", 128'(rsp_valid), 128'(0));
        rst_n  = 1'b1;
        mon_on = 1'b1;
        look(40'h00_0000_0000, "R1");
        look(40'hFF_FFFF_FFFF, "R1");
        idle();

        // R2: programming and populated flags
        wr(0, 32'h0000_0003);
        wr(1, 32'h0004_0007);
        wr(2, 32'h0040_0040);
        wr(3, 32'h0002_0020);
        check(cs_populated == 4'b1011, "R2", "populated map", 128'(cs_populated), 128'(4'b1011));

        look(40'h00_0000_0000, "R3");
        look(40'h00_0500_1234, "R3");
        look(40'h00_03FF_FFFF, "R4");   // last byte of CS0
        look(40'h00_0200_0000, "R6");   // CS0 and CS3 overlap
        look(40'h00_0800_0000, "R6");   // only CS3
        look(40'h00_20FF_FFFF, "R4");   // last byte of CS3
        look(40'h00_2100_0000, "R4");   // one past CS3 -> miss
        look(40'h00_4000_0000, "R5");   // only unpopulated CS2
        look(40'h00_4100_0000, "R7");
        idle();
        idle();
        check(rsp_valid == 1'b0, "R9", "valid after idle", 128'(rsp_valid), 128'(0));

        // R3: upper address bits
        wr(1, 32'h8000_80FF);
        look(40'h80_0100_0000, "R3");
        look(40'h80_FFFF_FFFF, "R8");
        look(40'h81_0000_0000, "R4");
        idle();

        // R10: reversed bounds
        wr(0, 32'h0005_0001);
        check(cs_populated[0] == 1'b1, "R10", "reversed populated", 128'(cs_populated[0]), 128'(1));
        look(40'h00_0000_0000, "R10");
        look(40'h00_0300_0000, "R10");
        idle();

        // R2: unpopulate by equal fields
        wr(3, 32'h0007_0007);
        check(cs_populated == 4'b0011, "R2", "populated after clear", 128'(cs_populated), 128'(4'b0011));
        look(40'h00_0700_0000, "R5");
        idle();

        // R11: write and lookup at the same edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0010_0011;
        lk_valid = 1'b1; lk_addr = 40'h00_1000_0000;
        sb.push_back(predict(40'h00_1000_0000, "R11"));
        model[2] = 32'h0010_0011;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        look(40'h00_1000_0000, "R11");
        idle();
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R3", "results outstanding", 128'(sb.size()), 128'(0));
        check(rsp_valid == 1'b0, "R9", "final idle", 128'(rsp_valid), 128'(0));
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule